// File: doc/BRIEF.md
# USB Host Frame Interval Timer

This block keeps the frame timing of a USB host. It holds a programmable frame length in bit times and runs a down counter that shows how many bit times are left in the current frame. When that counter has run out and one more bit time passes, the block emits a start-of-frame strobe. In the same clock it reloads the counter from the programmed length and loads a separate packet-budget counter with a programmed largest-packet size in bits. The scheduler can then compare the budget against the size of a pending transfer.

Software reaches the block through a command-coded register port. One register packs a toggle flag, the packet budget value and the frame length. The second register exposes the live remaining count and can also be written. Software may rewrite the frame length at any time. This lets frame timing follow an external reference. A new length takes effect only at the next frame start. A host-controller reset input returns the frame length to its nominal value of 11999. Time advances only on a bit-time enable input.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset the frame length reads 11999 (0x2EDF), the toggle flag and budget value read 0, the remaining count is 11999, the budget counter is 0, `budget_empty` is 1 and `sof_pulse` is 0.
- R2: Writing code 0x8D stores the toggle flag from bit 31, the budget value from bits 30:16 and the frame length from bits 13:0. Reading code 0x0D returns them in the same positions, with bits 15:14 always read as 0.
- R3: Each cycle with `bit_en` high and a nonzero remaining count lowers the count by one. Without `bit_en` the count holds.
- R4: A `bit_en` while the remaining count is 0 causes `sof_pulse` to be high for exactly the following cycle and reloads the count from the frame length. Frame starts are therefore spaced by the frame length plus one enable.
- R5: A frame length written mid-frame leaves the current frame's remaining count and spacing unchanged. It is used from the next reload onward.
- R6: At each frame start the budget counter loads the stored budget value. It then drops by one per `bit_en`, stays at 0 once there, and `budget_empty` is high exactly when it is 0.
- R7: A cycle with `hc_reset` high sets the frame length to 11999 and keeps the toggle flag and budget value.
- R8: Code 0x8E loads bits 13:0 of the write data into the remaining count. This takes priority over counting in the same cycle. Code 0x0E reads the count zero-extended to 32 bits.
- R9: Codes other than 0x0D, 0x0E, 0x8D and 0x8E read as 0, and writing them changes no state.
- R10: If `hc_reset` and a 0x8D write occur in the same cycle, the frame length becomes 11999.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hc_reset | input | 1 | Host-controller reset: frame length to nominal |
| bit_en | input | 1 | One bit time elapsed |
| cmd_valid | input | 1 | Command code is valid this cycle |
| cmd_code | input | 8 | Command code; bit 7 set means write |
| cmd_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for the current read code, else 0 |
| sof_pulse | output | 1 | One-cycle start-of-frame strobe |
| frame_remaining | output | 14 | Bit times left in the frame |
| pkt_budget | output | 15 | Packet budget counter |
| budget_empty | output | 1 | Budget counter is zero |

## Verification
The bench keeps the default parameters: a 14-bit frame counter, a 15-bit budget and the nominal length of 11999. A full nominal frame of 12000 enables therefore fits in the run and checks R4 at the real length. Short programmed lengths of 4, 7 and 9 make mid-frame rewrites, budget saturation and back-to-back frame starts cheap to reach.

// File: rtl/ft_pkg.sv
package ft_pkg;
  localparam logic [7:0] CODE_IVL_RD = 8'h0D;
  localparam logic [7:0] CODE_IVL_WR = 8'h8D;
  localparam logic [7:0] CODE_REM_RD = 8'h0E;
  localparam logic [7:0] CODE_REM_WR = 8'h8E;

  typedef enum logic [1:0] {SEL_NONE, SEL_IVL, SEL_REM} reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [7:0] code);
    case ({1'b0, code[6:0]})
      CODE_IVL_RD: decode_sel = SEL_IVL;
      CODE_REM_RD: decode_sel = SEL_REM;
      default:     decode_sel = SEL_NONE;
    endcase
  endfunction

  function automatic logic is_write(input logic [7:0] code);
    is_write = code[7];
  endfunction

  // Saturating decrement used by both counters.
  function automatic logic [31:0] sat_dec(input logic [31:0] v);
    sat_dec = (v == 32'd0) ? 32'd0 : v - 32'd1;
  endfunction
endpackage

// File: rtl/ft_counter.sv
module ft_counter #(
  parameter int W = 14,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] value,
  output logic         is_zero
);
  import ft_pkg::*;
  localparam int PADW = 32 - W;

  logic [31:0] dec_wide;
  assign dec_wide = sat_dec({{PADW{1'b0}}, value});

  always_ff @(posedge clk) begin
    if (!rst_n)     value <= RESET_VAL;
    else if (load)  value <= load_val;
    else if (dec)   value <= dec_wide[W-1:0];
  end

  assign is_zero = (value == '0);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !dec) |=> $stable(value));
  p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && dec && !is_zero) |=> (value == $past(value) - 1'b1));
  p_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && dec && is_zero) |=> is_zero);
  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (value == $past(load_val)));
endmodule

// File: rtl/ft_regs.sv
module ft_regs #(
  parameter int FI_W = 14,
  parameter int PB_W = 15,
  parameter int DATA_W = 32,
  parameter logic [FI_W-1:0] NOMINAL_FI = 14'd11999
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hc_reset,
  input  logic              wr_ivl,
  input  logic [DATA_W-1:0] wr_data,
  output logic [FI_W-1:0]   ivl_fi,
  output logic [PB_W-1:0]   ivl_pb,
  output logic              ivl_tog
);
  localparam int PB_LO = 16;
  localparam int TOG_BIT = DATA_W - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ivl_fi  <= NOMINAL_FI;
      ivl_pb  <= '0;
      ivl_tog <= 1'b0;
    end else begin
      if (wr_ivl) begin
        ivl_pb  <= wr_data[PB_LO +: PB_W];
        ivl_tog <= wr_data[TOG_BIT];
      end
      if (hc_reset)    ivl_fi <= NOMINAL_FI;
      else if (wr_ivl) ivl_fi <= wr_data[FI_W-1:0];
    end
  end

  p_hcr_nominal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hc_reset |=> (ivl_fi == NOMINAL_FI));
  p_hcr_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hc_reset && !wr_ivl) |=> ($stable(ivl_pb) && $stable(ivl_tog)));
  p_ivl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ivl && !hc_reset) |=> (ivl_fi == $past(wr_data[FI_W-1:0])));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ivl && !hc_reset) |=> ($stable(ivl_fi) && $stable(ivl_pb) && $stable(ivl_tog)));
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer #(
  parameter int FI_W = 14,
  parameter int PB_W = 15,
  parameter int DATA_W = 32,
  parameter logic [FI_W-1:0] NOMINAL_FI = 14'd11999
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hc_reset,
  input  logic              bit_en,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              sof_pulse,
  output logic [FI_W-1:0]   frame_remaining,
  output logic [PB_W-1:0]   pkt_budget,
  output logic              budget_empty
);
  import ft_pkg::*;
  localparam int PB_LO = 16;
  localparam int RSV_W = PB_LO - FI_W;

  logic            wr_ivl, wr_rem, rem_zero, frame_start, rem_load;
  logic [FI_W-1:0] ivl_fi, rem_load_val;
  logic [PB_W-1:0] ivl_pb;
  logic            ivl_tog;
  reg_sel_e        rd_sel;

  assign wr_ivl = cmd_valid && (cmd_code == CODE_IVL_WR);
  assign wr_rem = cmd_valid && (cmd_code == CODE_REM_WR);
  assign rd_sel = (cmd_valid && !is_write(cmd_code)) ? decode_sel(cmd_code) : SEL_NONE;

  ft_regs #(.FI_W(FI_W), .PB_W(PB_W), .DATA_W(DATA_W), .NOMINAL_FI(NOMINAL_FI)) u_regs (
    .clk(clk), .rst_n(rst_n), .hc_reset(hc_reset), .wr_ivl(wr_ivl),
    .wr_data(cmd_wdata), .ivl_fi(ivl_fi), .ivl_pb(ivl_pb), .ivl_tog(ivl_tog)
  );

  // Frame boundary: expiry plus one enable, unless software overwrites the count.
  assign frame_start  = bit_en && rem_zero && !wr_rem;
  assign rem_load     = wr_rem || frame_start;
  assign rem_load_val = wr_rem ? cmd_wdata[FI_W-1:0] : ivl_fi;

  ft_counter #(.W(FI_W), .RESET_VAL(NOMINAL_FI)) u_remain (
    .clk(clk), .rst_n(rst_n), .load(rem_load), .load_val(rem_load_val),
    .dec(bit_en), .value(frame_remaining), .is_zero(rem_zero)
  );

  ft_counter #(.W(PB_W), .RESET_VAL('0)) u_budget (
    .clk(clk), .rst_n(rst_n), .load(frame_start), .load_val(ivl_pb),
    .dec(bit_en), .value(pkt_budget), .is_zero(budget_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) sof_pulse <= 1'b0;
    else        sof_pulse <= frame_start;
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_IVL: begin
        rd_data[DATA_W-1]      = ivl_tog;
        rd_data[PB_LO +: PB_W] = ivl_pb;
        rd_data[FI_W-1:0]      = ivl_fi;
      end
      SEL_REM: rd_data[FI_W-1:0] = frame_remaining;
      default: rd_data = '0;
    endcase
  end

  p_sof_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (sof_pulse && frame_remaining == $past(ivl_fi)));
  p_sof_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |-> ($past(bit_en) && $past(rem_zero)));
  p_budget_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (pkt_budget == $past(ivl_pb)));
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == SEL_IVL) |-> (rd_data[FI_W +: RSV_W] == '0));
  p_unknown_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == SEL_NONE) |-> (rd_data == '0));
  p_mid_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ivl && !rem_load && bit_en && !rem_zero) |=> (frame_remaining == $past(frame_remaining) - 1'b1));
endmodule

// File: tb/usb_frame_timer_bench.sv
module usb_frame_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hc_reset = 1'b0;
  logic        bit_en = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_code = 8'h00;
  logic [31:0] cmd_wdata = 32'h0;
  logic [31:0] rd_data;
  logic        sof_pulse;
  logic [13:0] frame_remaining;
  logic [14:0] pkt_budget;
  logic        budget_empty;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  usb_frame_timer u_usb_frame_timer (
    .clk(clk), .rst_n(rst_n), .hc_reset(hc_reset), .bit_en(bit_en),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_wdata(cmd_wdata),
    .rd_data(rd_data), .sof_pulse(sof_pulse), .frame_remaining(frame_remaining),
    .pkt_budget(pkt_budget), .budget_empty(budget_empty)
  );

  always #4 clk = ~clk;

  // Vector: wcode[95:88] wdata[87:56] n_en[55:48] rcode[47:40] expect[39:8] req[7:0]
  localparam int NV = 11;
  localparam logic [95:0] VEC [NV] = '{
    {8'h00, 32'h0,         8'd0, 8'h0D, 32'h00002EDF, 8'd1},  // R1
    {8'h00, 32'h0,         8'd0, 8'h0E, 32'h00002EDF, 8'd1},  // R1
    {8'h8D, 32'hFFFFFFFF,  8'd0, 8'h0D, 32'hFFFF3FFF, 8'd2},  // R2 reserved read 0
    {8'h8D, 32'h80050009,  8'd0, 8'h0D, 32'h80050009, 8'd2},  // R2
    {8'h00, 32'h0,         8'd3, 8'h0E, 32'h00002EDC, 8'd5},  // R5 old frame runs on
    {8'h00, 32'h0,         8'd0, 8'h0E, 32'h00002EDC, 8'd3},  // R3 hold
    {8'h8E, 32'h00000002,  8'd0, 8'h0E, 32'h00000002, 8'd8},  // R8
    {8'h00, 32'h0,         8'd2, 8'h0E, 32'h00000000, 8'd3},  // R3
    {8'h00, 32'h0,         8'd1, 8'h0E, 32'h00000009, 8'd4},  // R4 reload new length
    {8'h8F, 32'hFFFFFFFF,  8'd0, 8'h0D, 32'h80050009, 8'd9},  // R9 unknown write
    {8'h8E, 32'hFFFFFFFF,  8'd0, 8'h0F, 32'h00000000, 8'd9}   // R9 unknown read
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] code, input logic [31:0] data);
    cmd_valid = 1'b1; cmd_code = code; cmd_wdata = data;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0; cmd_code = 8'h00; cmd_wdata = 32'h0;
  endtask

  task automatic do_read(input logic [7:0] code, output logic [31:0] val);
    cmd_valid = 1'b1; cmd_code = code;
    #1 val = rd_data;
    cmd_valid = 1'b0; cmd_code = 8'h00;
  endtask

  task automatic tick();
    bit_en = 1'b1;
    @(posedge clk); @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic ticks_to_sof(input int limit, output int n);
    n = 0;
    for (int i = 0; i < limit; i++) begin
      tick();
      n++;
      if (sof_pulse) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state at ports
    check("R1 sof", {31'b0, sof_pulse}, 32'h0);
    check("R1 budget", {17'b0, pkt_budget}, 32'h0);
    check("R1 empty", {31'b0, budget_empty}, 32'h1);

    for (int k = 0; k < NV; k++) begin
      logic [95:0] e;
      string tag;
      e = VEC[k];
      if (e[95:88] != 8'h00) do_write(e[95:88], e[87:56]);
      for (int j = 0; j < int'(e[55:48]); j++) tick();
      do_read(e[47:40], v);
      tag = $sformatf("R%0d vec%0d", e[7:0], k);
      check(tag, v, e[39:8]);
    end
    // R8 upper bits of 0x8E write dropped (last vector wrote all ones)
    do_read(8'h0E, v);
    check("R8 width", v, 32'h00003FFF);

    // R4/R6 frame spacing and budget
    do_write(8'h8D, 32'h00030004);
    do_write(8'h8E, 32'h0);
    ticks_to_sof(20, n);
    check("R4 first sof", n, 1);
    check("R4 reload", {18'b0, frame_remaining}, 32'd4);
    check("R6 load", {17'b0, pkt_budget}, 32'd3);
    ticks_to_sof(20, n);
    check("R4 spacing", n, 5);
    // R5 new length written just after SOF
    do_write(8'h8D, 32'h00030007);
    check("R5 current frame kept", {18'b0, frame_remaining}, 32'd4);
    ticks_to_sof(20, n);
    check("R5 old spacing", n, 5);
    // R6 budget drains and saturates
    for (int j = 0; j < 3; j++) tick();
    check("R6 drained", {17'b0, pkt_budget}, 32'd0);
    check("R6 empty", {31'b0, budget_empty}, 32'd1);
    tick();
    check("R6 saturate", {17'b0, pkt_budget}, 32'd0);
    ticks_to_sof(20, n);
    check("R5 new spacing", n, 4);
    ticks_to_sof(20, n);
    check("R5 full spacing", n, 8);
    check("R4 one cycle", {31'b0, sof_pulse}, 32'd1);
    @(posedge clk); @(negedge clk);
    check("R4 pulse ends", {31'b0, sof_pulse}, 32'd0);

    // R8 write beats counting
    cmd_valid = 1'b1; cmd_code = 8'h8E; cmd_wdata = 32'd5; bit_en = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0; cmd_code = 8'h00; bit_en = 1'b0;
    check("R8 priority", {18'b0, frame_remaining}, 32'd5);

    // R7 host-controller reset
    do_write(8'h8D, 32'h80030007);
    hc_reset = 1'b1; @(posedge clk); @(negedge clk); hc_reset = 1'b0;
    do_read(8'h0D, v);
    check("R7 nominal keeps rest", v, 32'h80032EDF);

    // R10 reset wins over write
    hc_reset = 1'b1;
    do_write(8'h8D, 32'h00010005);
    hc_reset = 1'b0;
    do_read(8'h0D, v);
    check("R10 nominal", v, 32'h00012EDF);

    // R1 reset mid-run, then a full nominal frame (R4)
    rst_n = 1'b0; @(posedge clk); @(negedge clk); rst_n = 1'b1;
    check("R1 remaining", {18'b0, frame_remaining}, 32'h2EDF);
    do_read(8'h0D, v);
    check("R1 interval", v, 32'h00002EDF);
    do_write(8'h8E, 32'h0);
    ticks_to_sof(20, n);
    ticks_to_sof(13000, n);
    check("R4 nominal spacing", n, 12000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule